// File: doc/BRIEF.md
# Cascaded Feedback Divider with Gated Phase Detector

This block is the digital half of the feedback loop in a video clock synthesizer. It runs on the synthesized output clock. That clock passes through a small load divider, which produces the load clock for an attached video DAC. In cascade mode, the load divider's terminal pulses then step a 12-bit line counter. The line counter's terminal pulse leaves the block as a one-cycle line-reset pulse. It also serves as the feedback event of a digital phase-frequency detector.

The detector compares feedback events with reference edges. A register bit selects which edge of the reference input counts. An optional reference pre-divider sits in front of the detector. A build-time parameter picks how the detector is gated off so that the loop free-runs through vertical blanking. One choice qualifies a bus data bit with a latched bus address. The other uses a blanking pin. A separate request input launches a one-shot realignment sequence on the load clock, which resets the pipeline of an attached DAC.

Top module: `vfb_feedback`

## Requirements
- R1: `ld_div_sel` picks the load modulus N1: code 0 gives 3, 1 gives 4, 2 gives 5, 3 gives 6, 4 gives 8, and 5, 6 and 7 give 10. `ld_clk` has a period of N1 cycles and is high for floor(N1/2) of them.
- R2: `line_reset` is a one-cycle pulse that repeats every N1*M cycles, where M is `line_mod`, or 1 when `line_mod` is 0.
- R3: A new `line_mod` value takes effect at the next terminal reload; the interval already under way keeps the old length.
- R4: With `ref_rise` = 1 only rising edges of `ref_in` count; with `ref_rise` = 0 only falling edges count. The other edge has no effect on `pump_up`. A qualifying edge raises `pump_up` on the third clock edge after `ref_in` changes.
- R5: The reference pre-divider passes one of every max(`ref_mod`,1) qualifying edges to the detector.
- R6: A reference event sets `pump_up`. A feedback event sets `pump_dn`. The feedback event is the `line_reset` pulse when `cascade_fb` = 1 and the load terminal pulse when it is 0. The clock after both outputs are high clears both.
- R7: Bus-gated variant (`GATE_BY_BLANK` = 0): the detector is disabled while `det_gate_en` = 1, the address last captured from `bus_data` while `bus_latch` was high equals 0xF, and `bus_data[3]` = 1. Any other address leaves it running, and `vblank_in` has no effect.
- R8: Blank-gated variant (`GATE_BY_BLANK` = 1): the detector is disabled while `det_gate_en` = 1 and `vblank_in` = 1. The bus has no effect.
- R9: While the detector is disabled, `pump_up` and `pump_dn` are low. After the disable is released, the first qualifying reference edge raises `pump_up` on the third clock edge after it.
- R10: A 1-to-0 transition of `realign_req` holds `ld_clk` low on clock edges 2 to RST_LEN+1 after the transition (RST_LEN = 8). The load count then restarts from zero, so with N1 = 4 `ld_clk` is high after edge RST_LEN+2.
- R11: During reset `pump_up`, `pump_dn`, `ld_clk` and `line_reset` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized output clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock input, sampled |
| ref_rise | input | 1 | 1: rising reference edges count, 0: falling |
| cascade_fb | input | 1 | 1: feedback through the load and line counters |
| ld_div_sel | input | 3 | Load modulus code |
| line_mod | input | 12 | Line counter modulus |
| ref_mod | input | 8 | Reference pre-divide ratio |
| det_gate_en | input | 1 | Enables detector gating |
| realign_req | input | 1 | Falling edge launches DAC realignment |
| bus_latch | input | 1 | Captures bus_data as address while high |
| bus_data | input | 4 | Address/data bus |
| vblank_in | input | 1 | Blanking input |
| pump_up | output | 1 | Detector up pulse |
| pump_dn | output | 1 | Detector down pulse |
| ld_clk | output | 1 | Load clock to the DAC |
| line_reset | output | 1 | Line-counter terminal pulse |

## Verification
A wrong load count appears within one load period as a `ld_clk` period or duty error. A wrong line count or reload shows up at the next `line_reset` as an interval of the wrong length. A modulus that loads too early shortens the interval that was already running. A detector that holds stale state shows as `pump_up` or `pump_dn` rising without a qualifying event, or staying high through a gate or past a both-high cycle. It is caught a few cycles after the reference edge that is driven. A mis-latched gate address shows on the very next reference edge as a pulse that is present when it should be absent, or absent when it should be present.

// File: rtl/vfb_pkg.sv
package vfb_pkg;

  localparam int LD_SEL_W = 3;
  localparam int LD_CNT_W = 4;

  function automatic logic [LD_CNT_W-1:0] ld_modulus(input logic [LD_SEL_W-1:0] sel);
    logic [LD_CNT_W-1:0] m;
    case (sel)
      3'd0:    m = 4'd3;
      3'd1:    m = 4'd4;
      3'd2:    m = 4'd5;
      3'd3:    m = 4'd6;
      3'd4:    m = 4'd8;
      default: m = 4'd10;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vfb_load_div.sv
module vfb_load_div
  import vfb_pkg::*;
#(
  parameter int RST_LEN = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LD_SEL_W-1:0] sel,
  input  logic                realign_req,
  output logic                ld_clk,
  output logic                tick
);
  localparam int SEQ_W = $clog2(RST_LEN + 1);

  logic [LD_CNT_W-1:0] modv, half, cnt, cnt_nxt;
  logic [SEQ_W-1:0]    seq_cnt;
  logic                req_q, busy, wrap;

  always_comb begin
    modv    = ld_modulus(sel);
    half    = modv >> 1;
    busy    = (seq_cnt != '0);
    wrap    = (cnt >= modv - 1'b1);
    cnt_nxt = (busy || wrap) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      ld_clk  <= 1'b0;
      tick    <= 1'b0;
      req_q   <= 1'b0;
      seq_cnt <= '0;
    end else begin
      req_q  <= realign_req;
      cnt    <= cnt_nxt;
      ld_clk <= !busy && (cnt_nxt < half);
      tick   <= !busy && wrap;
      if (req_q && !realign_req)
        seq_cnt <= SEQ_W'(RST_LEN);
      else if (busy)
        seq_cnt <= seq_cnt - 1'b1;
    end
  end

  AST_LD_RANGE: assert property (@(posedge clk) disable iff (rst)
    $stable(sel) |-> (cnt < modv)); // R1
  AST_LD_QUIET_SEQ: assert property (@(posedge clk) disable iff (rst)
    (seq_cnt != '0) && $past(seq_cnt != '0) |-> !ld_clk); // R10

endmodule

// File: rtl/vfb_line_div.sv
module vfb_line_div #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [LW-1:0] line_mod,
  output logic          line_reset
);
  logic [LW-1:0] cnt, reload;

  always_comb reload = (line_mod == '0) ? '0 : line_mod - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      line_reset <= 1'b0;
    end else begin
      line_reset <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          cnt        <= reload;
          line_reset <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_LINE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    line_reset |-> $past(tick)); // R2
  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_reset |=> !line_reset); // R2
  AST_LINE_MIDCOUNT: assert property (@(posedge clk) disable iff (rst)
    tick && (cnt != '0) |=> !line_reset); // R3

endmodule

// File: rtl/vfb_ref_path.sv
module vfb_ref_path #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_in,
  input  logic          ref_rise,
  input  logic [RW-1:0] ref_mod,
  output logic          ref_evt
);
  logic          ref_q, ref_qq, edge_hit;
  logic [RW-1:0] rcnt, last;

  always_comb begin
    edge_hit = ref_rise ? (ref_q && !ref_qq) : (!ref_q && ref_qq);
    last     = (ref_mod == '0) ? '0 : ref_mod - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      ref_qq  <= 1'b0;
      rcnt    <= '0;
      ref_evt <= 1'b0;
    end else begin
      ref_q   <= ref_in;
      ref_qq  <= ref_q;
      ref_evt <= 1'b0;
      if (edge_hit) begin
        if (rcnt >= last) begin
          rcnt    <= '0;
          ref_evt <= 1'b1;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  AST_REF_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    ref_evt |-> $past(ref_q != ref_qq)); // R5

endmodule

// File: rtl/vfb_gate.sv
module vfb_gate #(
  parameter bit            GATE_BY_BLANK = 1'b0,
  parameter int            AW            = 4,
  parameter logic [AW-1:0] GATE_ADDR     = '1,
  parameter int            DBIT          = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          det_gate_en,
  input  logic          bus_latch,
  input  logic [AW-1:0] bus_data,
  input  logic          vblank_in,
  output logic          gate
);
  logic [AW-1:0] addr_q;
  logic          cond_bus, cond_blank, cond;

  always_comb begin
    cond_bus   = det_gate_en && (addr_q == GATE_ADDR) && bus_data[DBIT];
    cond_blank = det_gate_en && vblank_in;
    cond       = GATE_BY_BLANK ? cond_blank : cond_bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      gate   <= 1'b0;
    end else begin
      if (bus_latch) addr_q <= bus_data;
      gate <= cond;
    end
  end

  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    gate |-> $past(det_gate_en)); // R7

endmodule

// File: rtl/vfb_pfd.sv
module vfb_pfd (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic pump_up,
  output logic pump_dn
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
      armed   <= 1'b1;
    end else if (gate) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
      armed   <= 1'b0;
    end else begin
      if (ref_evt) armed <= 1'b1;
      if (pump_up && pump_dn) begin
        pump_up <= 1'b0;
        pump_dn <= 1'b0;
      end else begin
        pump_up <= pump_up || ref_evt;
        pump_dn <= pump_dn || (fb_evt && (armed || ref_evt));
      end
    end
  end

  AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (rst)
    pump_up && pump_dn |=> !pump_up && !pump_dn); // R6
  AST_GATE_QUIET: assert property (@(posedge clk) disable iff (rst)
    gate |=> !pump_up && !pump_dn); // R9
  AST_UP_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(ref_evt)); // R6

endmodule

// File: rtl/vfb_feedback.sv
module vfb_feedback
  import vfb_pkg::*;
#(
  parameter bit GATE_BY_BLANK = 1'b0,
  parameter int LINE_W        = 12,
  parameter int REF_W         = 8,
  parameter int BUS_W         = 4,
  parameter int RST_LEN       = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_in,
  input  logic                ref_rise,
  input  logic                cascade_fb,
  input  logic [LD_SEL_W-1:0] ld_div_sel,
  input  logic [LINE_W-1:0]   line_mod,
  input  logic [REF_W-1:0]    ref_mod,
  input  logic                det_gate_en,
  input  logic                realign_req,
  input  logic                bus_latch,
  input  logic [BUS_W-1:0]    bus_data,
  input  logic                vblank_in,
  output logic                pump_up,
  output logic                pump_dn,
  output logic                ld_clk,
  output logic                line_reset
);
  logic ld_tick, ref_evt, gate, fb_evt;

  vfb_load_div #(.RST_LEN(RST_LEN)) u_load (
    .clk(clk), .rst(rst), .sel(ld_div_sel), .realign_req(realign_req),
    .ld_clk(ld_clk), .tick(ld_tick));

  vfb_line_div #(.LW(LINE_W)) u_line (
    .clk(clk), .rst(rst), .tick(ld_tick), .line_mod(line_mod),
    .line_reset(line_reset));

  vfb_ref_path #(.RW(REF_W)) u_ref (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_rise(ref_rise),
    .ref_mod(ref_mod), .ref_evt(ref_evt));

  vfb_gate #(.GATE_BY_BLANK(GATE_BY_BLANK), .AW(BUS_W)) u_gate (
    .clk(clk), .rst(rst), .det_gate_en(det_gate_en), .bus_latch(bus_latch),
    .bus_data(bus_data), .vblank_in(vblank_in), .gate(gate));

  always_comb fb_evt = cascade_fb ? line_reset : ld_tick;

  vfb_pfd u_pfd (
    .clk(clk), .rst(rst), .gate(gate), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .pump_up(pump_up), .pump_dn(pump_dn));

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) && rst |-> !pump_up && !pump_dn && !ld_clk && !line_reset); // R11

endmodule

// File: tb/vfb_feedback_tb.sv
module vfb_feedback_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_in = 1'b0, ref_rise = 1'b1, cascade_fb = 1'b1;
  logic [2:0]  ld_div_sel = 3'd1;
  logic [11:0] line_mod = 12'd4;
  logic [7:0]  ref_mod = 8'd1;
  logic        det_gate_en = 1'b0, realign_req = 1'b0, bus_latch = 1'b0;
  logic [3:0]  bus_data = 4'd0;
  logic        vblank_in = 1'b0;
  logic        up_a, dn_a, ld_a, lr_a, up_b, dn_b, ld_b, lr_b;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vfb_feedback #(.GATE_BY_BLANK(1'b0)) u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_rise(ref_rise), .cascade_fb(cascade_fb),
    .ld_div_sel(ld_div_sel), .line_mod(line_mod), .ref_mod(ref_mod),
    .det_gate_en(det_gate_en), .realign_req(realign_req), .bus_latch(bus_latch),
    .bus_data(bus_data), .vblank_in(vblank_in),
    .pump_up(up_a), .pump_dn(dn_a), .ld_clk(ld_a), .line_reset(lr_a));

  vfb_feedback #(.GATE_BY_BLANK(1'b1)) u_dut_blk (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_rise(ref_rise), .cascade_fb(cascade_fb),
    .ld_div_sel(ld_div_sel), .line_mod(line_mod), .ref_mod(ref_mod),
    .det_gate_en(det_gate_en), .realign_req(realign_req), .bus_latch(bus_latch),
    .bus_data(bus_data), .vblank_in(vblank_in),
    .pump_up(up_b), .pump_dn(dn_b), .ld_clk(ld_b), .line_reset(lr_b));

  // Vectors: load code, line modulus, expected load modulus
  localparam int NV = 9;
  localparam int V_SEL [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 0};
  localparam int V_LM  [NV] = '{5, 0, 7, 1, 3, 2, 2, 4, 4095};
  localparam int V_N1  [NV] = '{3, 4, 5, 6, 8, 10, 10, 10, 3};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_period(output int p);
    int c = 0;
    while (!lr_a && c < 30000) begin step(1); c++; end
    c = 0;
    do begin step(1); c++; end while (!lr_a && c < 30000);
    p = c;
  endtask

  task automatic load_shape(output int per, output int hi);
    int c = 0;
    logic prev;
    while (ld_a && c < 50) begin step(1); c++; end
    while (!ld_a && c < 50) begin step(1); c++; end
    per = 0; hi = 0; prev = 1'b1;
    forever begin
      if (ld_a) hi++;
      step(1); per++;
      if (!prev && ld_a) break;
      if (per > 40) break;
      prev = ld_a;
    end
  endtask

  // Qualifying reference edge under ref_rise = 1, driven right after a negedge
  task automatic qedge();
    ref_in = 1'b0; step(4);
    ref_in = 1'b1;
  endtask

  task automatic settle();
    bus_latch = 1'b1; bus_data = 4'hF; step(1);
    bus_latch = 1'b0; bus_data = 4'h8; vblank_in = 1'b1; det_gate_en = 1'b1;
    step(3);
    bus_data = 4'h0; vblank_in = 1'b0; det_gate_en = 1'b0;
    step(2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p, per, hi, lm;
    // R11: reset state
    step(3);
    chk("R11 up", int'(up_a), 0);
    chk("R11 dn", int'(dn_a), 0);
    chk("R11 ld_clk", int'(ld_a), 0);
    chk("R11 line_reset", int'(lr_a), 0);

    // R1 / R2 vector table
    for (int i = 0; i < NV; i++) begin
      rst = 1'b1;
      ld_div_sel = 3'(V_SEL[i]);
      line_mod = 12'(V_LM[i]);
      step(3);
      rst = 1'b0;
      step(5);
      load_shape(per, hi);
      chk("R1 load period", per, V_N1[i]);
      chk("R1 load high", hi, V_N1[i] / 2);
      lm = (V_LM[i] == 0) ? 1 : V_LM[i];
      line_period(p);
      chk("R2 line interval", p, V_N1[i] * lm);
    end

    // R3: modulus change applies at the next reload
    rst = 1'b1; ld_div_sel = 3'd0; line_mod = 12'd4; step(3);
    rst = 1'b0; step(2);
    line_period(p);
    chk("R3 start interval", p, 12);
    line_mod = 12'd2;
    p = 0;
    do begin step(1); p++; end while (!lr_a && p < 100);
    chk("R3 interval in flight", p, 12);
    p = 0;
    do begin step(1); p++; end while (!lr_a && p < 100);
    chk("R3 new interval", p, 6);

    // R10: realignment sequence with N1 = 4
    ld_div_sel = 3'd1; step(10);
    realign_req = 1'b1; step(3);
    realign_req = 1'b0;
    step(1);
    for (int k = 2; k <= 9; k++) begin
      step(1);
      chk("R10 ld_clk held low", int'(ld_a), 0);
    end
    step(1);
    chk("R10 ld_clk restarts high", int'(ld_a), 1);

    // Detector set-up: long cascade so feedback stays away
    rst = 1'b1; ld_div_sel = 3'd5; line_mod = 12'd4000; cascade_fb = 1'b1;
    ref_mod = 8'd1; ref_rise = 1'b1; ref_in = 1'b0;
    step(3); rst = 1'b0; step(30);
    settle();
    chk("R9 gate cleared up", int'(up_a), 0);
    chk("R9 gate cleared dn", int'(dn_a), 0);

    // R4 / R6: rising edge raises up on the third clock edge
    qedge();
    step(2);
    chk("R4 up not yet", int'(up_a), 0);
    step(1);
    chk("R4 rising edge raises up", int'(up_a), 1);
    // R6: non-cascade feedback clears both
    cascade_fb = 1'b0;
    p = 0;
    while (!(up_a && dn_a) && p < 30) begin step(1); p++; end
    chk("R6 both seen high", int'(up_a && dn_a), 1);
    step(1);
    chk("R6 both cleared", int'(up_a || dn_a), 0);
    cascade_fb = 1'b1;
    settle();

    // R4: falling edge ignored with ref_rise = 1
    ref_in = 1'b1; step(4);
    ref_in = 1'b0; step(6);
    chk("R4 falling ignored", int'(up_a), 0);
    // R4: falling edge counts with ref_rise = 0
    ref_rise = 1'b0;
    ref_in = 1'b1; step(6);
    chk("R4 rising ignored", int'(up_a), 0);
    ref_in = 1'b0; step(3);
    chk("R4 falling counts", int'(up_a), 1);
    ref_rise = 1'b1;
    settle();

    // R5: divide-by-3 reference
    ref_mod = 8'd3;
    qedge(); step(5);
    chk("R5 first edge held", int'(up_a), 0);
    qedge(); step(5);
    chk("R5 second edge held", int'(up_a), 0);
    qedge(); step(5);
    chk("R5 third edge passes", int'(up_a), 1);
    ref_mod = 8'd1;
    settle();

    // R7 / R8: gating sources
    bus_latch = 1'b1; bus_data = 4'hF; step(1);
    bus_latch = 1'b0; bus_data = 4'h8; det_gate_en = 1'b1; step(2);
    qedge(); step(5);
    chk("R7 bus gate blocks up", int'(up_a), 0);
    chk("R8 bus ignored by blank variant", int'(up_b), 1);
    bus_latch = 1'b1; bus_data = 4'hE; step(1);
    bus_latch = 1'b0; bus_data = 4'h8; step(2);
    qedge(); step(5);
    chk("R7 other address does not gate", int'(up_a), 1);
    bus_data = 4'h0; vblank_in = 1'b1; step(3);
    chk("R8 blank gate clears up", int'(up_b), 0);
    chk("R7 blank ignored by bus variant", int'(up_a), 1);
    qedge(); step(5);
    chk("R8 blank gate blocks up", int'(up_b), 0);

    // R9: resume on first edge after release
    vblank_in = 1'b0; det_gate_en = 1'b0; step(2);
    qedge(); step(2);
    chk("R9 up not yet after release", int'(up_b), 0);
    step(1);
    chk("R9 first edge after release", int'(up_b), 1);

    finish_run();
  end
endmodule